// File: doc/BRIEF.md
# Ternary-Masked Associative Pattern Matcher

This block is a small associative memory that stores coarse track patterns and reports which of them are compatible with the hits of one event. Each stored pattern spans eight layers. For each layer it holds a superbin identifier and a two-bit don't-care mask. A mask bit that is set removes the matching low bit of the superbin from the comparison. One stored entry can therefore match at fine resolution (nothing masked) or at coarse resolution (one or two low bits masked).

Hits arrive on eight per-layer buses, each with its own valid strobe. Every pattern keeps a sticky matched flag for each layer. When the end-of-event strobe arrives, the block counts the logical layers each pattern has matched. Every enabled pattern whose count reaches the programmable threshold becomes fired, and at the same time all matched flags are cleared for the next event. The two innermost physical layers can be merged into one logical layer: with the merge control set, that layer counts as matched when either physical layer matched. Each pattern has one disable flop that masks out a defective entry completely.

Fired patterns are read out through a valid/ready port, lowest index first. Each accepted index clears its fired flag. Patterns are written one (pattern, layer) cell at a time, and only while the array is idle.

Top module: `road_matcher`

## Requirements
- R1: After reset every pattern is disabled, every matched flag and fired flag is clear, and out_vld is 0; no event can fire a pattern until it has been loaded with wr_dis = 0.
- R2: A write (wr_en = 1) stores wr_sb and wr_mask into cell (wr_pat, wr_lay) and sets the disable flop of pattern wr_pat to wr_dis. It takes effect only when the array is idle, meaning no matched flag and no fired flag is set; otherwise the write is ignored.
- R3: A hit on layer l matches pattern p when, for every bit position k, either bit k is equal in the hit and in the stored superbin, or k < 2 and bit k of the stored mask for (p, l) is 1. Mask bit 0 covers superbin bit 0 and mask bit 1 covers superbin bit 1.
- R4: Matched flags are sticky: a matching hit sets them, and they stay set until eoe, which clears them all. Hits presented in the same cycle as eoe are discarded.
- R5: On eoe, a pattern becomes fired when its logical matched-layer count is greater than or equal to fire_thr, both sampled in that cycle. With fire_thr = 8 this means all eight layers matched.
- R6: A pattern whose disable flop is 1 never fires, whatever hits it sees.
- R7: With inner_merge = 1, physical layers 0 and 1 form a single logical layer that counts once if either of them matched, so the count is at most 7. With inner_merge = 0 all eight layers count separately.
- R8: While any fired flag is set, out_vld = 1 and out_idx gives the lowest fired index. A cycle with out_vld and out_rdy both 1 clears that flag. While out_rdy = 0, out_idx holds its value.
- R9: Once every fired index has been accepted, out_vld returns to 0 and the array is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Cell write strobe |
| wr_pat | input | 4 | Pattern index of the write |
| wr_lay | input | 3 | Layer index of the write |
| wr_sb | input | 12 | Superbin value to store |
| wr_mask | input | 2 | Don't-care mask for the low superbin bits |
| wr_dis | input | 1 | New value of the pattern's disable flop |
| hit_vld | input | 8 | Per-layer hit strobe |
| hit_sb | input | 96 | Per-layer hit superbins, layer l at bits [12l+11:12l] |
| eoe | input | 1 | End-of-event strobe |
| fire_thr | input | 4 | Logical layers needed to fire |
| inner_merge | input | 1 | Merge physical layers 0 and 1 by OR |
| out_rdy | input | 1 | Readout consumer ready |
| out_vld | output | 1 | A fired pattern is presented |
| out_idx | output | 4 | Index of the presented pattern |

## Verification
The bench builds the block with its default parameters: 16 patterns, 8 layers, 12-bit superbins and 2 mask bits. These sizes are small enough to load every cell of the bank, and they still expose the full width of the mask, a pattern index range that gives the priority encoder real work, and a threshold range that reaches both the merged maximum of 7 and the unmerged maximum of 8. Event scenarios cover full matches, masked and unmasked near-misses on the low bits, partial matches against lowered thresholds, both merge settings on the same hit set, a disabled entry that receives perfect hits, a write attempted while the array is busy, and readout under backpressure.

// File: rtl/road_matcher.sv
module road_matcher #(
  parameter int NPAT = 16,
  parameter int NLAY = 8,
  parameter int SBW  = 12,
  parameter int DCW  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NPAT)-1:0]     wr_pat,
  input  logic [$clog2(NLAY)-1:0]     wr_lay,
  input  logic [SBW-1:0]              wr_sb,
  input  logic [DCW-1:0]              wr_mask,
  input  logic                        wr_dis,
  input  logic [NLAY-1:0]             hit_vld,
  input  logic [NLAY*SBW-1:0]         hit_sb,
  input  logic                        eoe,
  input  logic [$clog2(NLAY+1)-1:0]   fire_thr,
  input  logic                        inner_merge,
  input  logic                        out_rdy,
  output logic                        out_vld,
  output logic [$clog2(NPAT)-1:0]     out_idx
);
  localparam int PW = $clog2(NPAT);
  localparam int CW = $clog2(NLAY+1);

  logic [NPAT-1:0][NLAY-1:0][SBW-1:0] sb_q;
  logic [NPAT-1:0][NLAY-1:0][DCW-1:0] dc_q;
  logic [NPAT-1:0][NLAY-1:0]          seen_q, hm;
  logic [NPAT-1:0]                    dis_q, fired_q, fire_now, sent;

  wire idle = (seen_q == '0) && (fired_q == '0);
  wire load = wr_en && idle;

  for (genvar p = 0; p < NPAT; p++) begin : g_pat
    for (genvar l = 0; l < NLAY; l++) begin : g_lay
      logic [SBW-1:0] care;
      assign care = ~{{(SBW-DCW){1'b0}}, dc_q[p][l]};
      assign hm[p][l] = hit_vld[l] &&
        (((hit_sb[l*SBW +: SBW] ^ sb_q[p][l]) & care) == '0);
    end

    logic [CW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int l = 0; l < NLAY; l++) begin
        if (inner_merge && l == 1)
          cnt = cnt + CW'(seen_q[p][1] && !seen_q[p][0]);
        else
          cnt = cnt + CW'(seen_q[p][l]);
      end
    end
    assign fire_now[p] = !dis_q[p] && (cnt >= fire_thr);
  end

  always_comb begin
    out_idx = '0;
    for (int i = NPAT-1; i >= 0; i--)
      if (fired_q[i]) out_idx = PW'(i);
  end
  assign out_vld = |fired_q;
  assign sent = (out_vld && out_rdy) ? (NPAT'(1) << out_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sb_q    <= '0;
      dc_q    <= '0;
      dis_q   <= '1;
      seen_q  <= '0;
      fired_q <= '0;
    end else begin
      if (load) begin
        sb_q[wr_pat][wr_lay] <= wr_sb;
        dc_q[wr_pat][wr_lay] <= wr_mask;
        dis_q[wr_pat]        <= wr_dis;
      end
      seen_q  <= eoe ? '0 : (seen_q | hm);
      fired_q <= (fired_q & ~sent) | (eoe ? fire_now : '0);
    end
  end

  a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> !dis_q[out_idx]);

  a_r4_eoe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    eoe |=> (seen_q == '0));

  a_r2_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !idle) |=> ($stable(sb_q) && $stable(dc_q) && $stable(dis_q)));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_rdy && !eoe) |=> (out_vld && $stable(out_idx)));

  a_r8_sent_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_rdy && !eoe) |=> !fired_q[$past(out_idx)]);

endmodule

// File: tb/road_matcher_test.sv
module road_matcher_test;
  localparam int NPAT = 16, NLAY = 8, SBW = 12, DCW = 2;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, wr_dis = 0, eoe = 0, inner_merge = 0, out_rdy = 0;
  logic [3:0] wr_pat = 0;
  logic [2:0] wr_lay = 0;
  logic [SBW-1:0] wr_sb = 0;
  logic [DCW-1:0] wr_mask = 0;
  logic [NLAY-1:0] hit_vld = 0;
  logic [NLAY*SBW-1:0] hit_sb = 0;
  logic [3:0] fire_thr = 8;
  logic out_vld;
  logic [3:0] out_idx;

  road_matcher uut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string cur_tag = "R8";
  int exp_q[$];

  bit [SBW-1:0] m_sb [NPAT][NLAY];
  bit [DCW-1:0] m_dc [NPAT][NLAY];
  bit           m_dis [NPAT];
  bit           m_seen [NPAT][NLAY];

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      report();
    end
  end

  // monitor: one accepted index per cycle with out_vld && out_rdy
  always @(negedge clk) begin
    if (rst_n && out_vld && out_rdy) begin
      if (exp_q.size() == 0) chk(0, cur_tag, out_idx, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(out_idx == e, cur_tag, out_idx, e);
      end
    end
  end

  task automatic load(int p, int l, bit [SBW-1:0] v, bit [DCW-1:0] m, bit d, bit apply);
    wr_en = 1; wr_pat = 4'(p); wr_lay = 3'(l); wr_sb = v; wr_mask = m; wr_dis = d;
    if (apply) begin m_sb[p][l] = v; m_dc[p][l] = m; m_dis[p] = d; end
    @(posedge clk); #2;
    wr_en = 0;
  endtask

  task automatic hit(int l, bit [SBW-1:0] v);
    hit_vld = '0; hit_sb = '0;
    hit_vld[l] = 1'b1;
    hit_sb[l*SBW +: SBW] = v;
    for (int p = 0; p < NPAT; p++) begin
      bit [SBW-1:0] care;
      care = ~{{(SBW-DCW){1'b0}}, m_dc[p][l]};
      if (((v ^ m_sb[p][l]) & care) == '0) m_seen[p][l] = 1;
    end
    @(posedge clk); #2;
    hit_vld = '0;
  endtask

  task automatic end_event(int thr, bit merge);
    fire_thr = 4'(thr); inner_merge = merge; eoe = 1;
    for (int p = 0; p < NPAT; p++) begin
      int c;
      c = 0;
      for (int l = 0; l < NLAY; l++) begin
        if (merge && l == 1) c += (m_seen[p][1] && !m_seen[p][0]) ? 1 : 0;
        else c += m_seen[p][l] ? 1 : 0;
      end
      if (!m_dis[p] && c >= thr) exp_q.push_back(p);
      for (int l = 0; l < NLAY; l++) m_seen[p][l] = 0;
    end
    @(posedge clk); #2;
    eoe = 0;
  endtask

  task automatic drain(string tag);
    cur_tag = tag;
    out_rdy = 1;
    for (int k = 0; k < 64 && exp_q.size() != 0; k++) @(posedge clk);
    @(posedge clk); #2;
    @(negedge clk);
    chk(out_vld == 0, "R9", out_vld, 0);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
    @(posedge clk); #2;
    out_rdy = 0;
  endtask

  function automatic bit [SBW-1:0] val(int p, int l);
    return SBW'(p*256 + l*16 + 4);
  endfunction

  task automatic full(int p, int skip_lo, int skip_hi);
    for (int l = 0; l < NLAY; l++)
      if (l < skip_lo || l > skip_hi) hit(l, val(p, l));
  endtask

  initial begin
    for (int p = 0; p < NPAT; p++) begin
      m_dis[p] = 1;
      for (int l = 0; l < NLAY; l++) begin m_sb[p][l] = 0; m_dc[p][l] = 0; m_seen[p][l] = 0; end
    end
    repeat (3) @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    chk(out_vld == 0, "R1", out_vld, 0);

    // R1: unloaded (disabled) patterns ignore zero hits at threshold 1
    for (int l = 0; l < NLAY; l++) hit(l, 0);
    end_event(1, 0);
    @(negedge clk);
    chk(out_vld == 0, "R1", out_vld, 0);

    // R2: load bank; pattern 5 disabled; masks on pattern 7/8 layer 2
    for (int p = 0; p < NPAT; p++)
      for (int l = 0; l < NLAY; l++)
        load(p, l, val(p, l),
             (p == 7 && l == 2) ? 2'b11 : (p == 8 && l == 2) ? 2'b01 : 2'b00,
             p == 5, 1);

    // R5 / R6: patterns 9, 3 and 5 all fully hit; 5 disabled
    full(9, 9, 9); full(3, 9, 9); full(5, 9, 9);
    end_event(8, 0);
    drain("R5");

    // R3: mask 11 on pattern 7 layer 2 hides both low bits
    for (int l = 0; l < NLAY; l++) hit(l, l == 2 ? (val(7, 2) ^ 12'h003) : val(7, l));
    end_event(8, 0);
    drain("R3");

    // R3: mask 01 on pattern 8 does not hide bit 1
    for (int l = 0; l < NLAY; l++) hit(l, l == 2 ? (val(8, 2) ^ 12'h002) : val(8, l));
    end_event(8, 0);
    drain("R3");

    // R3: mask 01 on pattern 8 hides bit 0
    for (int l = 0; l < NLAY; l++) hit(l, l == 2 ? (val(8, 2) ^ 12'h001) : val(8, l));
    end_event(8, 0);
    drain("R3");

    // R5: threshold 6, pattern 10 has six layers, pattern 12 has five
    full(10, 6, 7); full(12, 5, 7);
    end_event(6, 0);
    drain("R5");

    // R7: layers 0..6 of pattern 11; merged count 6, unmerged 7
    full(11, 7, 7);
    end_event(7, 1);
    drain("R7");
    full(11, 7, 7);
    end_event(7, 0);
    drain("R7");
    full(11, 0, 0);
    end_event(7, 1);
    drain("R7");

    // R2: write while busy is ignored (model not updated)
    hit(0, val(3, 0));
    load(3, 0, 12'hfff, 2'b00, 1, 0);
    end_event(8, 0);
    drain("R2");
    full(3, 9, 9);
    end_event(8, 0);
    drain("R2");

    // R4: matched flags cleared by eoe: half of pattern 3 in each of two events
    full(3, 4, 7);
    end_event(8, 0);
    drain("R4");
    full(3, 0, 3);
    end_event(8, 0);
    drain("R4");

    // R4: hit in the eoe cycle is discarded
    full(4, 7, 7);
    hit_vld = 8'h80; hit_sb = '0; hit_sb[7*SBW +: SBW] = val(4, 7);
    end_event(8, 0);
    hit_vld = '0;
    drain("R4");

    // R8: lowest index first with backpressure
    full(14, 9, 9); full(2, 9, 9); full(6, 9, 9);
    end_event(8, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_vld == 1 && out_idx == 2, "R8", out_idx, 2);
    end
    drain("R8");

    report();
  end
endmodule